// File: doc/BRIEF.md
# Byte-wide nonvolatile data store controller

This block sits between a processor's register bus and a 1024-byte nonvolatile byte array. Software reaches the array only indirectly: it loads a 10-bit location into a low and a high address register, moves bytes through a data register, and starts operations by setting bits in a control register. A read is quick. The selected byte lands in the data register one clock after the request.

A write is deliberately hard to start by accident. The write-enable bit must already be set. The key register must have received 8'h55 and then 8'hAA on the two bus accesses just before the request. The key register is write-only and has no storage behind it. An accepted write first erases the location to 8'hFF. An internal timer then runs for a fixed number of clocks, and at the end the new byte is programmed. Completion raises a sticky done flag that serves as the interrupt source.

The block has two resets. A power-on reset clears everything. A system reset clears the working registers. If a system reset arrives in the middle of a write, it also sets a sticky error flag, so software can tell that the write was lost and retry it. Only software or a power-on reset clears that flag.

Top module: `nvb_ctrl`

## Requirements
- R1: Register selects are 0 address low (bits 7:0), 1 address high (bits 9:8), 2 data, 3 control and 4 key. Bits 7:2 of the address high register read as 0 whatever is written.
- R2: The key register always reads 8'h00.
- R3: Setting control bit 0 (read-start) loads the byte at the current address into the data register on the next clock. Bit 0 reads 0 again from that same clock on.
- R4: Control bits 0 and 1 (write-start) are set only by writing 1. Writing 0 to either bit has no effect, and hardware clears each bit when its operation completes.
- R5: A write starts only if control bit 2 (write-enable) is already 1 before the control write that requests it. Bit 2 takes the written value on every control write.
- R6: A write starts only if the two bus accesses just before the control write were key writes of 8'h55 and then 8'hAA. Any other access in between, including a read, prevents the start.
- R7: The busy output is high for exactly WR_CYCLES clocks per accepted write. Control bit 1 reads 1 for the same period.
- R8: While busy is high, writes to the address and data registers are ignored.
- R9: Control bit 4 (done) and the done_irq output are set when a write completes. They stay set until software writes 0 to bit 4. Writing 1 to bit 4 has no effect.
- R10: An accepted write erases the location to 8'hFF when it starts and programs the new byte at the end. A write cut short by reset leaves 8'hFF in the location.
- R11: A system reset during a write sets control bit 3 (error), ends the write, and zeroes the address and data registers.
- R12: The error bit is cleared only by a control write with bit 3 at 0, or by power-on reset. A system reset leaves it unchanged.
- R13: After power-on reset, all registers read 0, including write-enable, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (counts as an access for the key sequence) |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | A write is in progress |
| done_irq | output | 1 | Write-complete flag |

## Verification
A timer that drifts from the write-start bit shows up at the ports as a busy pulse of the wrong length. It also shows up as a missing done flag, visible on the clock after the write should have ended. A wrong key-sequence state shows up as a busy rise that should not happen, or a missing one, on the clock after the control write. A wrong error or erase state stays hidden until software reads the control register, or reads the aborted location back, after the reset. The bench reads both back on the first accesses after that reset.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    typedef enum logic [2:0] {
        SEL_ALO = 3'd0,
        SEL_AHI = 3'd1,
        SEL_DAT = 3'd2,
        SEL_CTL = 3'd3,
        SEL_KEY = 3'd4
    } sel_e;

    localparam int B_RD   = 0;
    localparam int B_WR   = 1;
    localparam int B_EN   = 2;
    localparam int B_ERR  = 3;
    localparam int B_DONE = 4;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_HALF  = 2'd1,
        K_ARMED = 2'd2
    } key_e;
endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
    import nvb_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       clr,
    input  logic       acc,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = K_IDLE;
        end else if (acc) begin
            if (key_wr && wdata == KEY_FIRST)
                st_d = K_HALF;
            else if (key_wr && st_q == K_HALF && wdata == KEY_SECOND)
                st_d = K_ARMED;
            else
                st_d = K_IDLE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= K_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
    parameter int CYCLES = 16,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic start,
    output logic last,
    output logic active
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (start)
            cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last   = (cnt_q == CNT_W'(1));
    assign active = (cnt_q != '0);
endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       busy,
    output logic       done_irq
);
    localparam int AHI_W = ADDR_W - 8;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic [7:0]       alo;
        logic [AHI_W-1:0] ahi;
        logic [7:0]       dat;
        logic             rd_go;
        logic             wr_go;
        logic             wr_en;
        logic             err;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic       armed, t_last, t_active, start_wr;
    logic       mem_we;
    logic [7:0] mem_wdata, mem_rdata;

    nvb_unlock u_key (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (!rst_n),
        .acc    (bus_wr | bus_rd),
        .key_wr (bus_wr && bus_sel == SEL_KEY),
        .wdata  (bus_wdata),
        .armed  (armed)
    );

    nvb_timer #(.CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (!rst_n),
        .start  (start_wr),
        .last   (t_last),
        .active (t_active)
    );

    nvb_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  ({r_q.ahi, r_q.alo}),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        start_wr  = 1'b0;
        if (!rst_n) begin
            r_d.alo   = '0;
            r_d.ahi   = '0;
            r_d.dat   = '0;
            r_d.rd_go = 1'b0;
            r_d.wr_go = 1'b0;
            r_d.wr_en = 1'b0;
            r_d.done  = 1'b0;
            r_d.err   = r_q.err | r_q.wr_go;
        end else begin
            if (bus_wr) begin
                case (bus_sel)
                    SEL_ALO: if (!r_q.wr_go) r_d.alo = bus_wdata;
                    SEL_AHI: if (!r_q.wr_go) r_d.ahi = bus_wdata[AHI_W-1:0];
                    SEL_DAT: if (!r_q.wr_go && !r_q.rd_go) r_d.dat = bus_wdata;
                    SEL_CTL: begin
                        r_d.wr_en = bus_wdata[B_EN];
                        if (!bus_wdata[B_ERR])  r_d.err  = 1'b0;
                        if (!bus_wdata[B_DONE]) r_d.done = 1'b0;
                        if (!r_q.wr_go && !r_q.rd_go) begin
                            if (bus_wdata[B_RD]) begin
                                r_d.rd_go = 1'b1;
                            end else if (bus_wdata[B_WR] && armed && r_q.wr_en) begin
                                r_d.wr_go = 1'b1;
                                start_wr  = 1'b1;
                                mem_we    = 1'b1;
                                mem_wdata = ERASED;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            // hardware completion wins over a same-cycle software write
            if (r_q.rd_go) begin
                r_d.dat   = mem_rdata;
                r_d.rd_go = 1'b0;
            end
            if (r_q.wr_go && t_last) begin
                mem_we    = 1'b1;
                mem_wdata = r_q.dat;
                r_d.wr_go = 1'b0;
                r_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_sel)
            SEL_ALO: bus_rdata = r_q.alo;
            SEL_AHI: bus_rdata = 8'(r_q.ahi);
            SEL_DAT: bus_rdata = r_q.dat;
            SEL_CTL: bus_rdata = {3'b000, r_q.done, r_q.err, r_q.wr_en, r_q.wr_go, r_q.rd_go};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign busy     = r_q.wr_go;
    assign done_irq = r_q.done;
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk
    import nvb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [2:0]        bus_sel,
    input logic [7:0]        bus_wdata,
    input logic              busy,
    input logic              done_irq,
    input logic              t_active,
    input logic              t_last,
    input logic              armed,
    input logic              wr_en,
    input logic              err,
    input logic              rd_go,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dat
);
    a_r7_busy_tracks_timer: assert property (@(posedge clk) disable iff (!por_n)
        busy == t_active);

    a_r3_read_one_clock: assert property (@(posedge clk) disable iff (!por_n)
        rd_go |=> !rd_go);

    a_r9_done_on_finish: assert property (@(posedge clk) disable iff (!por_n)
        (busy && t_last && rst_n) |=> done_irq);

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (err && !(bus_wr && bus_sel == SEL_CTL && !bus_wdata[B_ERR])) |=> err);

    a_r11_abort_effects: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && busy) |=> (err && addr == '0 && dat == '0 && !busy));

    a_r8_regs_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (busy && rst_n) |=> ($stable(addr) && $stable(dat)));

    a_r6_start_needs_key: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(armed));

    a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(wr_en));
endmodule

bind nvb_ctrl nvb_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done_irq  (done_irq),
    .t_active  (t_active),
    .t_last    (t_last),
    .armed     (armed),
    .wr_en     (r_q.wr_en),
    .err       (r_q.err),
    .rd_go     (r_q.rd_go),
    .addr      ({r_q.ahi, r_q.alo}),
    .dat       (r_q.dat)
);

// File: tb/tb_nvb_ctrl.sv
`timescale 1ns/1ps
module tb_nvb_ctrl;
    localparam int WRC = 16;
    localparam logic [2:0] S_ALO = 3'd0, S_AHI = 3'd1, S_DAT = 3'd2, S_CTL = 3'd3, S_KEY = 3'd4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_sel = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       busy, done_irq;

    int n_chk = 0;
    int n_err = 0;

    nvb_ctrl #(.ADDR_W(10), .WR_CYCLES(WRC)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done_irq(done_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] s, input logic [7:0] d);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] s, output logic [7:0] v);
        bus_rd = 1'b1; bus_sel = s;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_addr(input logic [9:0] a);
        bw(S_ALO, a[7:0]);
        bw(S_AHI, {6'b0, a[9:8]});
    endtask

    // read keeps enable on, error and done untouched
    task automatic do_read(input logic [9:0] a, output logic [7:0] v);
        logic [7:0] c;
        set_addr(a);
        bw(S_CTL, 8'h1D);
        @(negedge clk);
        br(S_DAT, v);
        br(S_CTL, c);
        chk("R3 read-start self-clears", int'(c[0]), 0);
    endtask

    task automatic start_write(input logic [9:0] a, input logic [7:0] d);
        set_addr(a);
        bw(S_DAT, d);
        bw(S_KEY, 8'h55);
        bw(S_KEY, 8'hAA);
        bw(S_CTL, 8'h1E);
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        br(S_ALO, v); chk("R13 addr low after power-on", int'(v), 0);
        br(S_AHI, v); chk("R13 addr high after power-on", int'(v), 0);
        br(S_DAT, v); chk("R13 data after power-on", int'(v), 0);
        br(S_CTL, v); chk("R13 control (enable) after power-on", int'(v), 0);
        chk("R13 busy after power-on", int'(busy), 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        bw(S_AHI, 8'hFF); br(S_AHI, v); chk("R1 high address upper bits read 0", int'(v), 8'h03);
        bw(S_ALO, 8'hA5); br(S_ALO, v); chk("R1 low address", int'(v), 8'hA5);
        bw(S_KEY, 8'h5A); br(S_KEY, v); chk("R2 key reads zero", int'(v), 0);
        bw(S_KEY, 8'h55); br(S_KEY, v); chk("R2 key reads zero after 55", int'(v), 0);
    endtask

    task automatic t_write();
        logic [7:0] v;
        int cnt;
        bw(S_CTL, 8'h1C);
        start_write(10'h2C3, 8'h5A);
        chk("R7 busy after start", int'(busy), 1);
        br(S_CTL, v); chk("R7 write-start bit reads 1", int'(v[1]), 1);
        wait_idle(cnt);
        chk("R7 busy length", cnt + 1, WRC);
        chk("R9 done after write", int'(done_irq), 1);
        br(S_CTL, v); chk("R4 write-start cleared by hardware", int'(v[1]), 0);
        do_read(10'h2C3, v); chk("R10 programmed value", int'(v), 8'h5A);
        chk("R9 done held", int'(done_irq), 1);
        bw(S_CTL, 8'h1C); chk("R9 writing 1 keeps done", int'(done_irq), 1);
        bw(S_CTL, 8'h0C); chk("R9 done cleared by 0", int'(done_irq), 0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        int cnt;
        start_write(10'h011, 8'h77);
        bw(S_CTL, 8'h1C);
        chk("R4 writing 0 keeps write running", int'(busy), 1);
        bw(S_ALO, 8'hEE);
        bw(S_AHI, 8'h03);
        bw(S_DAT, 8'h99);
        wait_idle(cnt);
        br(S_ALO, v); chk("R8 addr low ignored while busy", int'(v), 8'h11);
        br(S_AHI, v); chk("R8 addr high ignored while busy", int'(v), 0);
        br(S_DAT, v); chk("R8 data ignored while busy", int'(v), 8'h77);
        do_read(10'h011, v); chk("R10 second write stored", int'(v), 8'h77);
        bw(S_CTL, 8'h0C);
    endtask

    task automatic t_gate();
        logic [7:0] v;
        bw(S_CTL, 8'h18);
        start_write(10'h011, 8'h22);
        chk("R5 no start without prior enable", int'(busy), 0);
        br(S_CTL, v); chk("R5 enable takes written value", int'(v[2]), 1);
        do_read(10'h011, v); chk("R5 location unchanged", int'(v), 8'h77);
    endtask

    task automatic t_key();
        logic [7:0] v;
        int cnt;
        bw(S_CTL, 8'h0C);
        set_addr(10'h011);
        bw(S_DAT, 8'h33);
        bw(S_KEY, 8'h55); br(S_KEY, v); bw(S_KEY, 8'hAA); bw(S_CTL, 8'h0E);
        chk("R6 read between keys blocks start", int'(busy), 0);
        bw(S_KEY, 8'h55); bw(S_KEY, 8'hAA); bw(S_DAT, 8'h33); bw(S_CTL, 8'h0E);
        chk("R6 write after keys blocks start", int'(busy), 0);
        bw(S_KEY, 8'hAA); bw(S_KEY, 8'h55); bw(S_CTL, 8'h0E);
        chk("R6 reversed keys block start", int'(busy), 0);
        bw(S_KEY, 8'h55); bw(S_KEY, 8'hAA); bw(S_CTL, 8'h0E);
        chk("R6 correct keys start write", int'(busy), 1);
        wait_idle(cnt);
        do_read(10'h011, v); chk("R6 keyed write stored", int'(v), 8'h33);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        bw(S_CTL, 8'h0C);
        start_write(10'h155, 8'h3C);
        repeat (3) @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk("R11 reset ends write", int'(busy), 0);
        br(S_CTL, v); chk("R11 error set by aborted write", int'(v[3]), 1);
        br(S_ALO, v); chk("R11 addr low zeroed", int'(v), 0);
        br(S_AHI, v); chk("R11 addr high zeroed", int'(v), 0);
        br(S_DAT, v); chk("R11 data zeroed", int'(v), 0);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        br(S_CTL, v); chk("R12 error survives idle system reset", int'(v[3]), 1);
        bw(S_CTL, 8'h1C);
        do_read(10'h155, v); chk("R10 aborted location erased", int'(v), 8'hFF);
        br(S_CTL, v); chk("R12 error kept by writing 1", int'(v[3]), 1);
        bw(S_CTL, 8'h14);
        br(S_CTL, v); chk("R12 error cleared by writing 0", int'(v[3]), 0);
        bw(S_CTL, 8'h1C);
        start_write(10'h155, 8'h3C);
        @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        br(S_CTL, v); chk("R11 error set again", int'(v[3]), 1);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        br(S_CTL, v); chk("R12 power-on reset clears error", int'(v), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_write();
        t_busy_ignore();
        t_gate();
        t_key();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements) act=timeout exp=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule